// File: doc/BRIEF.md
# Zero-Suppressing Pixel Readout Sequencer

A trigger pulse starts the readout of one pixel chip. The sequencer enables the chip and gives it a single-cycle next-event strobe. It then samples 256 consecutive 32-bit words from the chip data bus, one word every fourth clock. This turns the fast system clock into a word rate one quarter as fast. Words that are entirely zero carry no hits and are thrown away. Each remaining word is tagged with its 8-bit position in the readout and pushed as one 64-bit entry into an internal synchronous FIFO. When the last word has been sampled, the sequencer raises a one-clock done flag and goes back to waiting for a trigger.

Downstream logic pops the FIFO through a read strobe. The result is a sparse list of hits in which every entry carries its own position. If the FIFO has no room when a hit arrives, the hit is lost and a sticky overflow flag records the loss.

Top module: `pixrd_seq`

## Requirements
- R1: While reset is high and in the cycle after it, chip_en_o, next_evt_o, done_o and ovf_o are 0 and fifo_empty_o is 1.
- R2: A trigger sampled high at a clock edge while the sequencer is idle starts a readout. next_evt_o is 1 in the cycle after that edge only, and chip_en_o is 1 from that cycle on.
- R3: One readout takes exactly 256 words. Word k (k = 0..255) is sampled at the 4·(k+1)-th clock edge after the trigger edge, and chip_en_o stays high for 1024 cycles.
- R4: A word whose 32 bits are all zero creates no FIFO entry. Every non-zero word creates exactly one.
- R5: An entry holds the data word in bits [31:0], its position k in bits [39:32] and zeros in bits [63:40].
- R6: Entries leave the FIFO in ascending position order. A read strobe sampled while the FIFO is non-empty pops one entry, and that entry appears on fifo_data_o from the next cycle. A read strobe while the FIFO is empty changes neither fifo_data_o nor fifo_empty_o.
- R7: done_o is 1 for exactly one cycle, the cycle right after chip_en_o falls. This is the 1025th cycle after the trigger edge. The sequencer is idle afterwards.
- R8: A trigger that arrives during a readout or during the done cycle is ignored. The running readout keeps its timing, and no new readout starts.
- R9: With 256 entries stored, a further non-zero word is dropped and ovf_o becomes 1. ovf_o stays 1 until reset, and the stored entries are left intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Readout trigger strobe |
| pix_data_i | input | 32 | Pixel word from the chip |
| chip_en_o | output | 1 | Chip enable, high during a readout |
| next_evt_o | output | 1 | Single-cycle next-event strobe to the chip |
| fifo_rd_i | input | 1 | FIFO pop strobe |
| fifo_data_o | output | 64 | Popped FIFO entry (registered) |
| fifo_empty_o | output | 1 | FIFO holds no entries |
| done_o | output | 1 | One-cycle end-of-readout flag |
| ovf_o | output | 1 | Sticky hit-lost flag |

## Verification
The hardest condition to reach from the ports is the loss of a hit because the FIFO is full. Only a complete event in which all 256 words are non-zero fills the FIFO exactly, and that event must itself leave ovf_o at 0. The bench therefore runs such an event, leaves the FIFO unread, and triggers a second, sparse event. It then checks that ovf_o is set and stays set after a full drain, and that the drained entries are exactly those of the first event. Triggers that land in the middle of a readout and in the done cycle are also placed on purpose, and the done latency is measured to show that they were ignored.

// File: rtl/pixrd_pkg.sv
package pixrd_pkg;

    localparam int DATA_W  = 32;
    localparam int IDX_W   = 8;
    localparam int ENTRY_W = 64;
    localparam int PAD_W   = ENTRY_W - DATA_W - IDX_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_DONE = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic [PAD_W-1:0]  pad;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } hit_entry_t;

    function automatic hit_entry_t pack_hit(input logic [IDX_W-1:0] idx,
                                            input logic [DATA_W-1:0] data);
        hit_entry_t e;
        e.pad  = '0;
        e.idx  = idx;
        e.data = data;
        return e;
    endfunction

endpackage

// File: rtl/pixrd_tick.sv
module pixrd_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);

    // R3: consecutive word samples are never on adjacent clocks
    a_r3_tick_gap: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/pixrd_idx.sv
module pixrd_idx #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cnt_en,
    output logic [W-1:0] idx_o,
    output logic         cout_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            idx_o <= '0;
        end else if (cnt_en) begin
            idx_o <= idx_o + 1'b1;
        end
    end

    assign cout_o = cnt_en && (&idx_o);

    // R3: index steps by one per sampled word
    a_r3_idx_step: assert property (@(posedge clk) disable iff (rst)
        cnt_en |=> idx_o == $past(idx_o) + 1'b1);

    // R3: after the last word the index is back at zero for the next event
    a_r3_idx_wrap: assert property (@(posedge clk) disable iff (rst)
        cout_o |=> idx_o == '0);

endmodule

// File: rtl/pixrd_fifo.sv
module pixrd_fifo #(
    parameter int W  = 64,
    parameter int AW = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         full
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [AW:0]   level;
    logic          do_rd;

    assign do_rd = rd_en && !empty;
    assign empty = (level == '0);
    assign full  = (level == (AW+1)'(DEPTH));

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            level   <= '0;
            rd_data <= '0;
        end else begin
            if (wr_en) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (do_rd) begin
                rd_ptr  <= rd_ptr + 1'b1;
                rd_data <= mem[rd_ptr];
            end
            case ({wr_en, do_rd})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // R9: the writer never pushes into a full store
    a_r9_no_write_full: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !full);

    // R6: a read on an empty store leaves the output register untouched
    a_r6_empty_read_hold: assert property (@(posedge clk) disable iff (rst)
        (rd_en && empty) |=> $stable(rd_data));

endmodule

// File: rtl/pixrd_seq.sv
module pixrd_seq #(
    parameter int DIV     = 4,
    parameter int FIFO_AW = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        trig_i,
    input  logic [31:0] pix_data_i,
    output logic        chip_en_o,
    output logic        next_evt_o,
    input  logic        fifo_rd_i,
    output logic [63:0] fifo_data_o,
    output logic        fifo_empty_o,
    output logic        done_o,
    output logic        ovf_o
);
    import pixrd_pkg::*;

    seq_state_t        state;
    logic              nev_q;
    logic              ovf_q;
    logic              tick;
    logic [IDX_W-1:0]  idx;
    logic              cout;
    logic              word_nz;
    logic              hit_req;
    logic              fifo_wr;
    logic              fifo_full;
    hit_entry_t        hit;

    assign word_nz = |pix_data_i;
    assign hit_req = tick && word_nz;
    assign fifo_wr = hit_req && !fifo_full;
    assign hit     = pack_hit(idx, pix_data_i);

    pixrd_tick #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (state == ST_READ),
        .tick (tick)
    );

    pixrd_idx #(.W(IDX_W)) u_idx (
        .clk    (clk),
        .rst    (rst),
        .cnt_en (tick),
        .idx_o  (idx),
        .cout_o (cout)
    );

    pixrd_fifo #(.W(ENTRY_W), .AW(FIFO_AW)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (fifo_wr),
        .wr_data (hit),
        .rd_en   (fifo_rd_i),
        .rd_data (fifo_data_o),
        .empty   (fifo_empty_o),
        .full    (fifo_full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            nev_q <= 1'b0;
            ovf_q <= 1'b0;
        end else begin
            nev_q <= (state == ST_IDLE) && trig_i;
            if (hit_req && fifo_full) begin
                ovf_q <= 1'b1;
            end
            case (state)
                ST_IDLE: if (trig_i) state <= ST_READ;
                ST_READ: if (cout)   state <= ST_DONE;
                ST_DONE:             state <= ST_IDLE;
                default:             state <= ST_IDLE;
            endcase
        end
    end

    assign chip_en_o  = (state == ST_READ);
    assign done_o     = (state == ST_DONE);
    assign next_evt_o = nev_q;
    assign ovf_o      = ovf_q;

    // R2: the next-event strobe only appears while the chip is enabled
    a_r2_nev_in_read: assert property (@(posedge clk) disable iff (rst)
        next_evt_o |-> chip_en_o);

    // R2: the next-event strobe is one cycle wide
    a_r2_nev_single: assert property (@(posedge clk) disable iff (rst)
        next_evt_o |=> !next_evt_o);

    // R7: done lasts one cycle and is followed by idle
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (!done_o && !chip_en_o));

    // R8: a running readout only leaves through the done cycle
    a_r8_busy_holds: assert property (@(posedge clk) disable iff (rst)
        chip_en_o |=> (chip_en_o || done_o));

    // R9: the hit-lost flag never clears without reset
    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        ovf_o |=> ovf_o);

endmodule

// File: tb/pixrd_seq_bench.sv
`timescale 1ns/1ps
module pixrd_seq_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trig = 1'b0;
    logic [31:0] pix_data = '0;
    logic        chip_en;
    logic        next_evt;
    logic        rd = 1'b0;
    logic [63:0] fdata;
    logic        fempty;
    logic        done;
    logic        ovf;

    int total = 0;
    int bad   = 0;
    int cur_mode = 0;
    int en_cnt = 0;

    always #2.5 clk = ~clk;

    pixrd_seq u_pixrd_seq (
        .clk          (clk),
        .rst          (rst),
        .trig_i       (trig),
        .pix_data_i   (pix_data),
        .chip_en_o    (chip_en),
        .next_evt_o   (next_evt),
        .fifo_rd_i    (rd),
        .fifo_data_o  (fdata),
        .fifo_empty_o (fempty),
        .done_o       (done),
        .ovf_o        (ovf)
    );

    // stimulus table: pattern mode and the number of hits it must leave
    localparam int NVEC = 5;
    localparam int VEC_MODE [NVEC] = '{0, 1, 2, 3, 4};
    localparam int VEC_HITS [NVEC] = '{0, 256, 37, 2, 128};

    function automatic logic [31:0] pat(input int mode, input int k);
        case (mode)
            1: return {8'(k), 24'hC35A1E};
            2: return (k % 7 == 0) ? {8'hA5, 16'h0000, 8'(k)} : 32'h0;
            3: return (k == 0 || k == 255) ? (32'hFFFFFFFF ^ 32'(k)) : 32'h0;
            4: return (k % 2 == 1) ? 32'h80000000 : 32'h0;
            default: return 32'h0;
        endcase
    endfunction

    // chip model: word k is presented during enabled cycles 4k..4k+3
    always @(negedge clk) begin
        if (chip_en) begin
            pix_data <= pat(cur_mode, en_cnt >> 2);
            en_cnt   <= en_cnt + 1;
        end else begin
            pix_data <= '0;
            en_cnt   <= 0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_event(input int mode, input bit poke);
        int lat;
        int en_cycles;
        cur_mode = mode;
        @(negedge clk);
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        lat = 1;
        en_cycles = chip_en ? 1 : 0;
        chk(next_evt == 1'b1, "R2", "next_evt after trigger", next_evt, 1);
        chk(chip_en == 1'b1, "R2", "chip_en after trigger", chip_en, 1);
        @(negedge clk);
        lat++;
        if (chip_en) en_cycles++;
        chk(next_evt == 1'b0, "R2", "next_evt width", next_evt, 0);
        while (!done && lat < 2000) begin
            if (poke && lat == 100) trig = 1'b1;
            @(negedge clk);
            trig = 1'b0;
            lat++;
            if (chip_en) en_cycles++;
        end
        chk(lat == 1025, "R7", "done latency", lat, 1025);
        chk(en_cycles == 1024, "R3", "enabled cycles", en_cycles, 1024);
        chk(chip_en == 1'b0, "R7", "chip_en during done", chip_en, 0);
        if (poke) trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        chk(done == 1'b0, "R7", "done width", done, 0);
        if (poke) begin
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (chip_en) begin
                    chk(1'b0, "R8", "late trigger restarted readout", 1, 0);
                    break;
                end
            end
            chk(chip_en == 1'b0, "R8", "idle after ignored triggers", chip_en, 0);
        end
    endtask

    task automatic drain_check(input int mode, input int exp_hits, input string req);
        int k = 0;
        int got = 0;
        int errs = 0;
        logic [63:0] exp;
        @(negedge clk);
        while (!fempty && got < 300) begin
            rd = 1'b1;
            @(posedge clk);
            @(negedge clk);
            rd = 1'b0;
            while (k < 256 && pat(mode, k) == 32'h0) k++;
            exp = (k < 256) ? {24'h0, 8'(k), pat(mode, k)} : 64'hDEAD;
            if (fdata !== exp) begin
                if (errs == 0)
                    $display("FAIL %s entry %0d (R5/R6 layout): actual=%0h expected=%0h",
                             req, got, fdata, exp);
                errs++;
            end
            k++;
            got++;
        end
        chk(got == exp_hits, "R4", "stored hit count", got, exp_hits);
        total++;
        if (errs != 0) bad++;
    endtask

    initial begin
        #(5.0 * 150000);
        bad++;
        $display("FAIL R3 watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] hold;
        rst = 1'b1;
        repeat (4) @(negedge clk);
        chk(chip_en == 1'b0 && next_evt == 1'b0, "R1", "enables in reset", chip_en, 0);
        chk(done == 1'b0 && ovf == 1'b0, "R1", "flags in reset", {done, ovf}, 0);
        chk(fempty == 1'b1, "R1", "empty in reset", fempty, 1);
        rst = 1'b0;
        @(negedge clk);
        chk(chip_en == 1'b0 && fempty == 1'b1, "R1", "idle after reset", chip_en, 0);

        // table walk: one event per row, drained and compared
        for (int v = 0; v < NVEC; v++) begin
            run_event(VEC_MODE[v], 1'b0);
            chk(ovf == 1'b0, "R9", "no overflow on single event", ovf, 0);
            drain_check(VEC_MODE[v], VEC_HITS[v], "R4");
        end

        // R6: read strobe on empty store changes nothing
        hold = fdata;
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        @(negedge clk);
        chk(fdata == hold, "R6", "data after empty read", fdata, hold);
        chk(fempty == 1'b1, "R6", "empty after empty read", fempty, 1);

        // R8: triggers mid-readout and in the done cycle are ignored
        run_event(3, 1'b1);
        drain_check(3, 2, "R8");

        // R9: fill exactly, then overflow with a second event
        run_event(1, 1'b0);
        chk(ovf == 1'b0, "R9", "exact fill sets no overflow", ovf, 0);
        run_event(2, 1'b0);
        chk(ovf == 1'b1, "R9", "overflow after full", ovf, 1);
        drain_check(1, 256, "R9");
        chk(ovf == 1'b1, "R9", "overflow sticky after drain", ovf, 1);
        run_event(0, 1'b0);
        chk(ovf == 1'b1, "R9", "overflow sticky after event", ovf, 1);

        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(ovf == 1'b0, "R1", "overflow cleared by reset", ovf, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule